// File: doc/BRIEF.md
# Oversampling Clock Recovery Loop

This block rebuilds a bit clock from a serial input that arrives without one. It counts ticks of a faster reference enable, and a select input sets that reference to 8, 16 or 32 ticks per nominal bit. At start it sits in the **SEARCH** state with its phase counter parked at zero. The first data transition moves it to the **TRACK** state and restarts the count from that edge. From then on, each transition is compared with the point where the count wraps, and the count is moved by one tick toward it. The data is sampled at mid-bit. A one-cycle strobe marks each sample, and a square-wave clock rises at that point. The clock can drive a receiver, a transmitter, or both.

The state transitions are: SEARCH to TRACK, named *lock*, taken on a ticked cycle that sees a transition while enabled; TRACK to SEARCH, named *drop*, taken whenever enable is low; and SEARCH to SEARCH, named *idle*, taken otherwise. A bypass input replaces the recovered clock with an externally supplied clock. The strobe and the tracking logic keep running while bypass is set.

Top module: `dpll_recover`

## Requirements
- R1: While reset is asserted, and once it is released, `tracking`, `bit_strobe`, `bit_data` and (with bypass low) `rec_clk` are 0.
- R2: `rate_sel` picks N ticks per bit: 2'b00 gives 8, 2'b01 gives 16, 2'b10 and 2'b11 give 32. With on-time edges, strobes are exactly N ticks apart. The select may only change while enable is low.
- R3: In SEARCH the phase stays at 0 and no strobe appears. The first transition seen while enabled makes `tracking` go high and sets the phase to 1.
- R4: In TRACK, a transition seen when the phase is in 1..N/2-1 (the edge is late) holds the phase for one tick, which lengthens that count to N+1 ticks.
- R5: In TRACK, a transition seen when the phase is in N/2..N-1 (the edge is early) advances the phase by two, modulo N, which shortens that count to N-1 ticks.
- R6: In TRACK, a transition seen at phase 0 leaves the count at its nominal length.
- R7: A tick in TRACK with the phase equal to N/2 raises `bit_strobe` for exactly one clock, and `bit_data` takes the synchronized data bit. No strobe occurs outside TRACK.
- R8: `rx_data` goes through two synchronizer stages that reset to 0. A change driven before tick k is acted on at tick k+2, so `tracking` rises after the third ticked edge.
- R9: With `bypass` high, `rec_clk` equals `ext_clk` combinationally. Otherwise it is high in TRACK while the phase is at least N/2, and low at all other times.
- R10: With `enable` low, the next clock edge returns the block to SEARCH with the phase at 0.
- R11: On clocks where `os_tick` is low, the phase, the state and the synchronizer all keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the loop; low forces SEARCH |
| os_tick | input | 1 | Oversampling reference enable, one pulse per reference tick |
| rate_sel | input | 2 | Ticks per bit select (8/16/32) |
| bypass | input | 1 | Route ext_clk to rec_clk |
| ext_clk | input | 1 | Externally supplied clock for bypass |
| rx_data | input | 1 | Asynchronous serial data |
| rec_clk | output | 1 | Recovered (or bypassed) bit clock, rising at mid-bit |
| bit_strobe | output | 1 | One-cycle sample marker |
| bit_data | output | 1 | Bit sampled at the last strobe |
| tracking | output | 1 | High in TRACK |

## Verification
The assertions check the following on every cycle: that disabling forces SEARCH, that SEARCH keeps the phase at zero, that the first edge sets the phase to one, that on-time and late edges produce the right next phase, that the strobe lasts a single cycle and appears only while tracking, and that nothing moves without a tick. Three things can only be shown by the bench scenarios. The first is that data running slow, on rate or fast produces strobe intervals of N+1, N or N-1 ticks at each rate. The second is that alternating input data comes back alternating. The third is the exact three-tick delay from a line change to lock. A cycle-level reference model in the bench compares every output under random data jitter, gapped ticks and bypass toggling.

// File: rtl/dpll_pkg.sv
package dpll_pkg;
    typedef enum logic {
        ST_SEARCH = 1'b0,
        ST_TRACK  = 1'b1
    } dpll_state_t;

    localparam int MIN_LOG2 = 3;             // smallest ratio is 2**3 = 8
    localparam int CNT_W    = MIN_LOG2 + 2;  // phase wide enough for 32
endpackage

// File: rtl/dpll_edge_sync.sv
module dpll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic din,
    output logic dout,
    output logic edge_o
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    chain[i] <= 1'b0;
                else if (tick)
                    chain[i] <= (i == 0) ? din : chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prev <= 1'b0;
        else if (tick)
            prev <= chain[STAGES-1];
    end

    assign dout   = chain[STAGES-1];
    assign edge_o = chain[STAGES-1] ^ prev;

    // R11: synchronizer frozen without a tick
    p_sync_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(dout));
endmodule

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
    import dpll_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        enable,
    input  logic        tick,
    input  logic        edge_i,
    output dpll_state_t state_o,
    output logic        tracking
);
    dpll_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SEARCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SEARCH: if (enable && tick && edge_i) state_d = ST_TRACK; // lock
            ST_TRACK:  if (!enable)                  state_d = ST_SEARCH; // drop
            default:   state_d = ST_SEARCH;
        endcase
    end

    always_comb begin
        state_o  = state_q;
        tracking = (state_q == ST_TRACK);
    end

    p_disable_search_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !tracking);
    p_notick_state_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(state_q));
endmodule

// File: rtl/dpll_phase_ctr.sv
module dpll_phase_ctr
    import dpll_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  dpll_state_t      state_i,
    input  logic             edge_i,
    input  logic             data_i,
    input  logic [1:0]       rate_sel,
    output logic [CNT_W-1:0] phase_o,
    output logic             strobe_o,
    output logic             bit_o,
    output logic             clk_o
);
    localparam int W1 = CNT_W + 1;

    logic [CNT_W-1:0] phase_q, phase_d;
    logic [W1-1:0]    n_ticks, half, ph_ext, inc1, inc2;
    logic             at_mid;

    always_comb begin
        unique case (rate_sel)
            2'b00:   n_ticks = W1'(1) << MIN_LOG2;
            2'b01:   n_ticks = W1'(1) << (MIN_LOG2 + 1);
            default: n_ticks = W1'(1) << (MIN_LOG2 + 2);
        endcase
        half   = n_ticks >> 1;
        ph_ext = {1'b0, phase_q};
        inc1   = (ph_ext + W1'(1) >= n_ticks) ? '0 : ph_ext + W1'(1);
        inc2   = (ph_ext + W1'(2) >= n_ticks) ? ph_ext + W1'(2) - n_ticks
                                              : ph_ext + W1'(2);
        at_mid = (ph_ext == half);
    end

    always_comb begin
        phase_d = phase_q;
        if (!enable)
            phase_d = '0;
        else if (tick) begin
            unique case (state_i)
                ST_SEARCH: phase_d = edge_i ? CNT_W'(1) : '0;
                ST_TRACK: begin
                    if (edge_i && ph_ext != '0 && ph_ext < half)
                        phase_d = phase_q;              // late edge: lengthen
                    else if (edge_i && ph_ext >= half)
                        phase_d = inc2[CNT_W-1:0];      // early edge: shorten
                    else
                        phase_d = inc1[CNT_W-1:0];
                end
                default: phase_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q  <= '0;
            strobe_o <= 1'b0;
            bit_o    <= 1'b0;
        end else begin
            phase_q  <= phase_d;
            strobe_o <= 1'b0;
            if (enable && tick && state_i == ST_TRACK && at_mid) begin
                strobe_o <= 1'b1;
                bit_o    <= data_i;
            end
        end
    end

    assign phase_o = phase_q;
    assign clk_o   = (state_i == ST_TRACK) && (ph_ext >= half);

    p_search_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SEARCH) |-> (phase_q == '0));
    p_first_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_i == ST_SEARCH && edge_i) |=> (phase_q == CNT_W'(1)));
    p_ontime_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_i == ST_TRACK && edge_i && phase_q == '0) |=> (phase_q == CNT_W'(1)));
    p_late_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && tick && state_i == ST_TRACK && edge_i && phase_q != '0 && ph_ext < half) |=> $stable(phase_q));
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);
    p_strobe_track_r7: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (state_i == ST_TRACK));
    p_notick_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> $stable(phase_q));
endmodule

// File: rtl/dpll_recover.sv
module dpll_recover
    import dpll_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       os_tick,
    input  logic [1:0] rate_sel,
    input  logic       bypass,
    input  logic       ext_clk,
    input  logic       rx_data,
    output logic       rec_clk,
    output logic       bit_strobe,
    output logic       bit_data,
    output logic       tracking
);
    logic             data_s, edge_s, loop_clk;
    dpll_state_t      state;
    logic [CNT_W-1:0] phase;

    dpll_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick(os_tick), .din(rx_data),
        .dout(data_s), .edge_o(edge_s)
    );

    dpll_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(os_tick),
        .edge_i(edge_s), .state_o(state), .tracking(tracking)
    );

    dpll_phase_ctr u_ctr (
        .clk(clk), .rst_n(rst_n), .enable(enable), .tick(os_tick),
        .state_i(state), .edge_i(edge_s), .data_i(data_s),
        .rate_sel(rate_sel), .phase_o(phase), .strobe_o(bit_strobe),
        .bit_o(bit_data), .clk_o(loop_clk)
    );

    assign rec_clk = bypass ? ext_clk : loop_clk;

    p_no_strobe_search_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !tracking |-> !bit_strobe);
    p_bypass_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bypass && !tracking) |-> !rec_clk);
endmodule

// File: tb/dpll_recover_tb_top.sv
module dpll_recover_tb_top;
    logic clk = 0, rst_n = 0, enable = 0, os_tick = 1, bypass = 0, ext_clk = 0, rx_data = 0;
    logic [1:0] rate_sel = 2'b00;
    logic rec_clk, bit_strobe, bit_data, tracking;
    int checks = 0, fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dpll_recover dut_i (.clk(clk), .rst_n(rst_n), .enable(enable), .os_tick(os_tick),
        .rate_sel(rate_sel), .bypass(bypass), .ext_clk(ext_clk), .rx_data(rx_data),
        .rec_clk(rec_clk), .bit_strobe(bit_strobe), .bit_data(bit_data), .tracking(tracking));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
        end
    endtask

    function automatic int ratio(input logic [1:0] s);
        return (s == 2'b00) ? 8 : (s == 2'b01) ? 16 : 32;
    endfunction

    // reference model built from the requirements
    logic m_s1, m_s2, m_prev, m_track, m_stb, m_dat;
    int   m_ph, mn;
    bit   me;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_track <= 0; m_stb <= 0; m_dat <= 0; m_ph <= 0;
        end else begin
            mn = ratio(rate_sel);
            me = m_s2 ^ m_prev;
            m_stb <= 0;
            if (os_tick) begin m_s1 <= rx_data; m_s2 <= m_s1; m_prev <= m_s2; end
            if (!enable) begin m_track <= 0; m_ph <= 0; end
            else if (os_tick) begin
                if (!m_track) begin
                    if (me) begin m_track <= 1; m_ph <= 1; end
                end else begin
                    if (m_ph == mn/2) begin m_stb <= 1; m_dat <= m_s2; end
                    if (me && m_ph != 0 && m_ph < mn/2) m_ph <= m_ph;
                    else if (me && m_ph >= mn/2)        m_ph <= (m_ph + 2) % mn;
                    else                                m_ph <= (m_ph + 1) % mn;
                end
            end
        end
    end

    // per-cycle comparison against the model
    bit cmp_on = 0;
    always @(negedge clk) begin
        cyc++;
        if (cmp_on) begin
            chk(tracking == m_track, "R3/R10 tracking", tracking, m_track);
            chk(bit_strobe == m_stb, "R7 strobe", bit_strobe, m_stb);
            if (m_stb) chk(bit_data == m_dat, "R7 data", bit_data, m_dat);
            chk(rec_clk == (bypass ? ext_clk : (m_track && m_ph >= ratio(rate_sel)/2)),
                "R9 rec_clk", rec_clk, bypass ? ext_clk : (m_track && m_ph >= ratio(rate_sel)/2));
        end
    end

    // strobe interval monitor for the directed rate tests
    bit meas_on = 0;
    int exp_iv, nstb, last_t;
    logic last_bit;
    string meas_tag;
    always @(negedge clk) begin
        if (meas_on && bit_strobe) begin
            if (nstb >= 3) begin
                chk(cyc - last_t == exp_iv, meas_tag, cyc - last_t, exp_iv);
                chk(bit_data != last_bit, "R7 alternation", bit_data, !last_bit);
            end
            last_t = cyc; last_bit = bit_data; nstb++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic alt_run(input logic [1:0] rs, input int period, input string tag);
        enable = 0; rate_sel = rs; step(2);
        enable = 1; exp_iv = period; nstb = 0; meas_tag = tag; meas_on = 1;
        for (int b = 0; b < 24; b++) begin rx_data = ~rx_data; step(period); end
        meas_on = 0;
        chk(nstb >= 20, {tag, " strobe count"}, nstb, 20);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1234));
        step(3);
        // R1: during and after reset
        #3;
        chk(tracking == 0 && bit_strobe == 0 && rec_clk == 0 && bit_data == 0, "R1 reset", tracking, 0);
        rst_n = 1; step(1);
        cmp_on = 1;
        chk(tracking == 0 && rec_clk == 0, "R1 post-reset", tracking, 0);
        // R3: search holds without transitions
        enable = 1; step(40);
        chk(tracking == 0 && bit_strobe == 0, "R3 search idle", tracking, 0);
        // R2/R4/R5/R6 via strobe spacing
        alt_run(2'b00, 8,  "R6 on-time x8");
        alt_run(2'b00, 9,  "R4 late x8");
        alt_run(2'b00, 7,  "R5 early x8");
        alt_run(2'b01, 16, "R2 x16");
        alt_run(2'b01, 17, "R4 late x16");
        alt_run(2'b10, 32, "R2 x32");
        alt_run(2'b11, 31, "R5 early x32 sel3");
        // R8: synchronizer latency to lock
        enable = 0; rate_sel = 2'b00; step(4);
        enable = 1; step(2);
        rx_data = ~rx_data; step(2);
        #1 chk(tracking == 0, "R8 not yet", tracking, 0);
        step(1);
        #1 chk(tracking == 1, "R8 lock after third tick", tracking, 1);
        // R11: no ticks, nothing moves
        os_tick = 0; rx_data = ~rx_data; step(30);
        #1 chk(tracking == 1 && bit_strobe == 0, "R11 frozen", bit_strobe, 0);
        os_tick = 1; step(1);
        // R10: enable low returns to search
        enable = 0; step(1);
        #1 chk(tracking == 0, "R10 drop", tracking, 0);
        enable = 1;
        // R9: bypass follows ext_clk immediately
        bypass = 1;
        for (int i = 0; i < 6; i++) begin
            ext_clk = ~ext_clk; #1;
            chk(rec_clk == ext_clk, "R9 bypass", rec_clk, ext_clk);
            step(1);
        end
        bypass = 0; ext_clk = 0;
        // random: jittered bits, gapped ticks, bypass, enable drops
        for (int r = 0; r < 600; r++) begin
            int n, len;
            if (r % 150 == 0) begin
                enable = 0; step(1);
                rate_sel = 2'($urandom_range(0, 3)); enable = 1;
            end
            n = ratio(rate_sel);
            rx_data = 1'($urandom_range(0, 1));
            len = n + $urandom_range(0, 2) - 1;
            for (int t = 0; t < len; t++) begin
                os_tick = ($urandom_range(0, 9) != 0);
                bypass  = ($urandom_range(0, 19) == 0);
                ext_clk = 1'($urandom_range(0, 1));
                step(1);
            end
        end
        os_tick = 1; bypass = 0;
        step(2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule